// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block sits beside a small microcontroller core and decides which clocks run. While the core runs, it picks between the low-speed internal clock and the high-speed clock. The choice comes from a high-speed select bit and a 3-bit divider code. It powers the fast oscillator on request, but only hands the fast clock to the system once the oscillator has had time to settle. That settling time is modelled by a counter of `STABLE_CYCLES` cycles.

A halt request from the core moves the block into one of four low-power modes. The mode is chosen from three configuration bits: idle-enable, watchdog-enable and keep-system-clock. Each mode gates its own set of clock enables (system, watchdog, time-base, sub-clock). Entering any halt mode sets a sticky power-down flag and issues one-cycle clear strobes to the watchdog counter and to the watchdog timeout flag. A wake-up request returns the block to running mode and re-enables the clocks, and a one-cycle resume pulse marks the return.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode output is 0 (running), the power-down flag is 0, the fast clock is not in use, and the strobes `wdtClr`, `toClr` and `resumePulse` are 0.
- R2: While running, with `fastSel`=0 and `divCode` equal to 000 or 001, `fastOscEn` and `useFastClk` are 0 (slow mode on the low-speed clock).
- R3: While running, with `fastSel`=1 or `divCode` in 010..111, `fastOscEn` is 1 in the same cycle. `fastStable` rises after `STABLE_CYCLES` rising edges with `fastOscEn` high, and `useFastClk` is 1 only when both are high. When `fastOscEn` drops, `useFastClk` drops at once and `fastStable` is 0 after the next edge.
- R4: A halt with `idleEn`=0 and `wdtEn`=0 enters mode 1 (deep sleep, watchdog off). In this mode all four clock enables and `fastOscEn` are 0.
- R5: A halt with `idleEn`=0 and `wdtEn`=1 enters mode 2 (sleep with watchdog). Here `sysClkEn`=0, `tbClkEn`=0, `wdtClkEn`=1 and `subClkEn`=1.
- R6: A halt with `idleEn`=1 and `keepSysClk`=0 enters mode 3 (idle, system clock stopped). Here `sysClkEn`=0, `tbClkEn`=1, `subClkEn`=1 and `wdtClkEn` equals `wdtEn`. The fast oscillator is off.
- R7: A halt with `idleEn`=1 and `keepSysClk`=1 enters mode 4 (idle, system clock kept). Here `sysClkEn`, `tbClkEn` and `subClkEn` are 1, `wdtClkEn` equals `wdtEn`, and the fast oscillator and its stable state are kept.
- R8: In the cycle after a halt is accepted, `pdFlag`, `wdtClr` and `toClr` are 1. The two strobes last one cycle, and `pdFlag` stays 1 until reset.
- R9: A wake request while halted returns the mode to 0 on the next edge. In that cycle `resumePulse` is 1 for one cycle and the running clock set is back (`sysClkEn`, `tbClkEn`, `subClkEn` = 1, `wdtClkEn` = `wdtEn`). After modes 1 to 3 the fast clock must settle again.
- R10: `haltReq` has no effect while halted, and `wakeReq` has no effect while running. When both arrive together while running, the halt is taken and no resume pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| haltReq | input | 1 | Halt request from the core |
| wakeReq | input | 1 | Wake-up event (interrupt or watchdog timeout) |
| idleEn | input | 1 | Idle-enable configuration bit |
| wdtEn | input | 1 | Watchdog-enable configuration bit |
| keepSysClk | input | 1 | Keep-system-clock-in-idle bit |
| fastSel | input | 1 | High-speed clock select bit |
| divCode | input | 3 | Clock divider code |
| modeOut | output | 3 | Current mode: 0 run, 1..4 halt modes |
| sysClkEn | output | 1 | System clock enable |
| wdtClkEn | output | 1 | Watchdog clock enable |
| tbClkEn | output | 1 | Time-base clock enable |
| subClkEn | output | 1 | Sub-clock enable |
| fastOscEn | output | 1 | Fast oscillator power enable |
| fastStable | output | 1 | Fast oscillator settled |
| useFastClk | output | 1 | System clock mux picks the fast clock |
| pdFlag | output | 1 | Sticky power-down flag |
| wdtClr | output | 1 | One-cycle watchdog counter clear |
| toClr | output | 1 | One-cycle watchdog timeout flag clear |
| resumePulse | output | 1 | One-cycle pulse on return to running |

## Verification
Halt acceptance and wake-up can meet in the same cycle. The bench raises `haltReq` and `wakeReq` on the same edge twice: once while running, where the halt must be taken with no resume pulse, and once while halted, where the wake must be taken with no new clear strobes. A second overlap is a halt into the mode that keeps the system clock while the fast clock is stable. The bench judges it by `fastStable` and `useFastClk` staying high through the halt and after the wake, while a deep-sleep halt must force a new settling wait.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;
  localparam int MODE_W = 3;
  localparam int DIV_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN    = 3'd0,
    MODE_SLEEP0 = 3'd1,
    MODE_SLEEP1 = 3'd2,
    MODE_IDLE0  = 3'd3,
    MODE_IDLE1  = 3'd4
  } pmode_t;

  typedef struct packed {
    logic enterHalt;
    logic leaveHalt;
    logic oscAllowed;
  } ctlStrobe_t;
endpackage

// File: rtl/pwr_clk_ctl.sv
module pwr_clk_ctl
  import pwr_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       haltReq,
  input  logic       wakeReq,
  input  logic       idleEn,
  input  logic       wdtEn,
  input  logic       keepSysClk,
  output pmode_t     mode,
  output ctlStrobe_t strobe,
  output logic       sysClkEn,
  output logic       wdtClkEn,
  output logic       tbClkEn,
  output logic       subClkEn
);
  pmode_t modeNxt;

  always_comb begin
    modeNxt          = mode;
    strobe.enterHalt = 1'b0;
    strobe.leaveHalt = 1'b0;
    if (mode == MODE_RUN) begin
      if (haltReq) begin
        strobe.enterHalt = 1'b1;
        if (idleEn) modeNxt = keepSysClk ? MODE_IDLE1 : MODE_IDLE0;
        else        modeNxt = wdtEn ? MODE_SLEEP1 : MODE_SLEEP0;
      end
    end else if (wakeReq) begin
      strobe.leaveHalt = 1'b1;
      modeNxt          = MODE_RUN;
    end
  end

  assign strobe.oscAllowed = (mode == MODE_RUN) || (mode == MODE_IDLE1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_RUN;
    else        mode <= modeNxt;
  end

  // Clock gating set per mode
  always_comb begin
    sysClkEn = 1'b1;
    tbClkEn  = 1'b1;
    subClkEn = 1'b1;
    wdtClkEn = wdtEn;
    unique case (mode)
      MODE_SLEEP0: begin
        sysClkEn = 1'b0; tbClkEn = 1'b0; subClkEn = 1'b0; wdtClkEn = 1'b0;
      end
      MODE_SLEEP1: begin
        sysClkEn = 1'b0; tbClkEn = 1'b0; subClkEn = 1'b1; wdtClkEn = 1'b1;
      end
      MODE_IDLE0: begin
        sysClkEn = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_clk_dp.sv
module pwr_clk_dp
  import pwr_clk_pkg::*;
#(
  parameter int STABLE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strobe,
  input  logic             fastSel,
  input  logic [DIV_W-1:0] divCode,
  output logic             fastOscEn,
  output logic             fastStable,
  output logic             useFastClk,
  output logic             pdFlag,
  output logic             wdtClr,
  output logic             toClr,
  output logic             resumePulse
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

  logic [CNT_W-1:0] settleCnt;
  logic             wantFast;

  // Codes 000 and 001 keep the low-speed clock; anything above asks for fast
  assign wantFast   = fastSel | (|divCode[DIV_W-1:1]);
  assign fastOscEn  = wantFast & strobe.oscAllowed;
  assign fastStable = (settleCnt == CNT_W'(STABLE_CYCLES));
  assign useFastClk = fastOscEn & fastStable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           settleCnt <= '0;
    else if (!fastOscEn)  settleCnt <= '0;
    else if (!fastStable) settleCnt <= settleCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdFlag      <= 1'b0;
      wdtClr      <= 1'b0;
      toClr       <= 1'b0;
      resumePulse <= 1'b0;
    end else begin
      if (strobe.enterHalt) pdFlag <= 1'b1;
      wdtClr      <= strobe.enterHalt;
      toClr       <= strobe.enterHalt;
      resumePulse <= strobe.leaveHalt;
    end
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
#(
  parameter int STABLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       haltReq,
  input  logic       wakeReq,
  input  logic       idleEn,
  input  logic       wdtEn,
  input  logic       keepSysClk,
  input  logic       fastSel,
  input  logic [2:0] divCode,
  output logic [2:0] modeOut,
  output logic       sysClkEn,
  output logic       wdtClkEn,
  output logic       tbClkEn,
  output logic       subClkEn,
  output logic       fastOscEn,
  output logic       fastStable,
  output logic       useFastClk,
  output logic       pdFlag,
  output logic       wdtClr,
  output logic       toClr,
  output logic       resumePulse
);
  pmode_t     mode;
  ctlStrobe_t strobe;

  pwr_clk_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .haltReq(haltReq), .wakeReq(wakeReq),
    .idleEn(idleEn), .wdtEn(wdtEn), .keepSysClk(keepSysClk),
    .mode(mode), .strobe(strobe),
    .sysClkEn(sysClkEn), .wdtClkEn(wdtClkEn), .tbClkEn(tbClkEn), .subClkEn(subClkEn)
  );

  pwr_clk_dp #(.STABLE_CYCLES(STABLE_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fastSel(fastSel), .divCode(divCode),
    .fastOscEn(fastOscEn), .fastStable(fastStable), .useFastClk(useFastClk),
    .pdFlag(pdFlag), .wdtClr(wdtClr), .toClr(toClr), .resumePulse(resumePulse)
  );

  assign modeOut = mode;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
  parameter int STABLE_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       haltReq,
  input logic       wakeReq,
  input logic       idleEn,
  input logic       wdtEn,
  input logic [2:0] modeOut,
  input logic       sysClkEn,
  input logic       wdtClkEn,
  input logic       tbClkEn,
  input logic       subClkEn,
  input logic       fastOscEn,
  input logic       fastStable,
  input logic       useFastClk,
  input logic       pdFlag,
  input logic       wdtClr,
  input logic       toClr,
  input logic       resumePulse
);
  logic [15:0] onRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         onRun <= '0;
    else if (!fastOscEn) onRun <= '0;
    else if (onRun != 16'hFFFF) onRun <= onRun + 16'd1;
  end

  AST_FAST_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    useFastClk |-> (fastStable && onRun >= 16'(STABLE_CYCLES))); // R3
  AST_SLEEP0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd1) |-> (!sysClkEn && !wdtClkEn && !tbClkEn && !subClkEn && !fastOscEn)); // R4
  AST_SLEEP1_WDT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd2) |-> (!sysClkEn && !tbClkEn && wdtClkEn)); // R5
  AST_IDLE0_TB_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd3) |-> (!sysClkEn && tbClkEn && subClkEn && (wdtClkEn == wdtEn))); // R6
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd0 && haltReq) |=> (pdFlag && wdtClr && toClr && modeOut != 3'd0)); // R8
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdtClr |=> !wdtClr); // R8
  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pdFlag |=> pdFlag); // R8
  AST_WAKE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut != 3'd0 && wakeReq) |=> (resumePulse && modeOut == 3'd0 && sysClkEn)); // R9
  AST_NO_STRAY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut == 3'd0) |=> !resumePulse); // R10
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.STABLE_CYCLES(STABLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .haltReq(haltReq), .wakeReq(wakeReq),
  .idleEn(idleEn), .wdtEn(wdtEn), .modeOut(modeOut),
  .sysClkEn(sysClkEn), .wdtClkEn(wdtClkEn), .tbClkEn(tbClkEn), .subClkEn(subClkEn),
  .fastOscEn(fastOscEn), .fastStable(fastStable), .useFastClk(useFastClk),
  .pdFlag(pdFlag), .wdtClr(wdtClr), .toClr(toClr), .resumePulse(resumePulse)
);

// File: tb/pwr_clk_ctrl_tb.sv
module pwr_clk_ctrl_tb;
  localparam int STABLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic haltReq = 0, wakeReq = 0, idleEn = 0, wdtEn = 0, keepSysClk = 0, fastSel = 0;
  logic [2:0] divCode = 3'd0;
  logic [2:0] modeOut;
  logic sysClkEn, wdtClkEn, tbClkEn, subClkEn, fastOscEn, fastStable, useFastClk;
  logic pdFlag, wdtClr, toClr, resumePulse;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  pwr_clk_ctrl #(.STABLE_CYCLES(STABLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .haltReq(haltReq), .wakeReq(wakeReq),
    .idleEn(idleEn), .wdtEn(wdtEn), .keepSysClk(keepSysClk),
    .fastSel(fastSel), .divCode(divCode), .modeOut(modeOut),
    .sysClkEn(sysClkEn), .wdtClkEn(wdtClkEn), .tbClkEn(tbClkEn), .subClkEn(subClkEn),
    .fastOscEn(fastOscEn), .fastStable(fastStable), .useFastClk(useFastClk),
    .pdFlag(pdFlag), .wdtClr(wdtClr), .toClr(toClr), .resumePulse(resumePulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Pack enables {sys, wdt, tb, sub}
  function automatic int ens();
    return {sysClkEn, wdtClkEn, tbClkEn, subClkEn};
  endfunction

  task automatic doHalt();
    haltReq = 1; step(); haltReq = 0;
  endtask

  task automatic doWake();
    wakeReq = 1; step(); wakeReq = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", modeOut, 0);
    chk("R1 pdFlag", pdFlag, 0);
    chk("R1 useFastClk", useFastClk, 0);
    chk("R1 strobes", {wdtClr, toClr, resumePulse}, 0);
  endtask

  task automatic t_slow();
    fastSel = 0; divCode = 3'b000; step();
    chk("R2 code000 fastOscEn", fastOscEn, 0);
    divCode = 3'b001; step();
    chk("R2 code001 fastOscEn", fastOscEn, 0);
    chk("R2 code001 useFastClk", useFastClk, 0);
  endtask

  task automatic t_settle();
    divCode = 3'b101;
    #1 chk("R3 osc on same cycle", fastOscEn, 1);
    step(STABLE - 1);
    chk("R3 not yet stable", fastStable, 0);
    chk("R3 not yet fast", useFastClk, 0);
    step();
    chk("R3 stable", fastStable, 1);
    chk("R3 fast in use", useFastClk, 1);
    divCode = 3'b000;
    #1 chk("R3 drop fast at once", useFastClk, 0);
    step();
    chk("R3 stable cleared", fastStable, 0);
    fastSel = 1;
    step(STABLE);
    chk("R3 select bit path stable", useFastClk, 1);
  endtask

  task automatic t_sleep0();
    idleEn = 0; wdtEn = 0; keepSysClk = 0;
    doHalt();
    chk("R4 mode", modeOut, 1);
    chk("R4 enables", ens(), 4'b0000);
    chk("R4 fastOscEn", fastOscEn, 0);
    chk("R8 pdFlag", pdFlag, 1);
    chk("R8 clear strobes", {wdtClr, toClr}, 2'b11);
    step();
    chk("R8 strobes one cycle", {wdtClr, toClr}, 2'b00);
    doHalt();
    chk("R10 halt ignored while halted mode", modeOut, 1);
    chk("R10 halt ignored while halted strobe", wdtClr, 0);
    doWake();
    chk("R9 back to run", modeOut, 0);
    chk("R9 resume pulse", resumePulse, 1);
    chk("R9 run enables", ens(), 4'b1011);
    chk("R9 resettle needed", useFastClk, 0);
    chk("R8 pdFlag sticky", pdFlag, 1);
    step();
    chk("R9 resume one cycle", resumePulse, 0);
    step(STABLE - 1);
    chk("R9 stable again", useFastClk, 1);
  endtask

  task automatic t_sleep1();
    idleEn = 0; wdtEn = 1;
    doHalt();
    chk("R5 mode", modeOut, 2);
    chk("R5 enables", ens(), 4'b0101);
    doWake();
    chk("R9 run enables wdt on", ens(), 4'b1111);
    step(STABLE);
  endtask

  task automatic t_idle0();
    idleEn = 1; keepSysClk = 0; wdtEn = 0;
    doHalt();
    chk("R6 mode", modeOut, 3);
    chk("R6 enables wdt off", ens(), 4'b0011);
    wdtEn = 1;
    #1 chk("R6 enables wdt on", ens(), 4'b0111);
    chk("R6 fast osc off", fastOscEn, 0);
    doWake();
    step(STABLE);
  endtask

  task automatic t_idle1();
    idleEn = 1; keepSysClk = 1; wdtEn = 1;
    chk("R7 stable before", fastStable, 1);
    doHalt();
    chk("R7 mode", modeOut, 4);
    chk("R7 enables", ens(), 4'b1111);
    chk("R7 fast kept", useFastClk, 1);
    step(3);
    doWake();
    chk("R7 fast kept after wake", useFastClk, 1);
    chk("R9 resume from idle1", resumePulse, 1);
    step();
  endtask

  task automatic t_collide();
    wakeReq = 1; step(); wakeReq = 0;
    chk("R10 wake ignored while running", {modeOut, resumePulse}, 0);
    idleEn = 0; wdtEn = 1;
    haltReq = 1; wakeReq = 1; step(); haltReq = 0; wakeReq = 0;
    chk("R10 halt wins mode", modeOut, 2);
    chk("R10 halt wins no resume", resumePulse, 0);
    step();
    haltReq = 1; wakeReq = 1; step(); haltReq = 0; wakeReq = 0;
    chk("R10 wake taken when halted", modeOut, 0);
    chk("R10 no new clear", wdtClr, 0);
    chk("R10 resume", resumePulse, 1);
  endtask

  task automatic t_reset_again();
    rst_n = 0; #1;
    chk("R1 pdFlag cleared by reset", pdFlag, 0);
    chk("R1 slow after reset", useFastClk, 0);
    step(); rst_n = 1; step();
    chk("R1 mode after reset", modeOut, 0);
  endtask

  initial begin
    #(20 * 20000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1;
    step();
    t_reset();
    t_slow();
    t_settle();
    t_sleep0();
    t_sleep1();
    t_idle0();
    t_idle1();
    t_collide();
    t_reset_again();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule